// File: doc/BRIEF.md
# Dual-Channel ADC Serial Reader

This block is the host side of a three-wire serial link to a two-channel sampling converter. A one-cycle `start` pulse makes it drop the active-low select `cs_n`. It then drives a serial clock `sclk` derived from the system clock and shifts the converter's data in from `sdata`. Every result on the wire is laid out the same way: two zeros first, then a 12-bit word with the MSB first, and in the long format two more zeros at the end. The block throws away these framing zeros. When the frame ends it raises `done` for one cycle and holds the words in `result_a` and `result_b`.

Two mode inputs are read at `start`. `len16` picks 16 serial clocks per result (0 gives 14). `dual` keeps the select low for a second result segment on the same data line, so both channels come back in one frame of 28 or 32 clocks. Data is sampled on the rising edge of the serial clock. The converter changes its data on falling edges, so each bit has half a serial period to settle. After each frame the block holds the select high for a programmable quiet time before it will accept a new start.

The controller has five states. IDLE waits for a start. SETUP holds the select low with the clock high for one half period. SHIFT toggles the clock and counts the rising edges. FINISH raises the select and strobes done. QUIET counts out the gap between frames. The transitions are: IDLE→SETUP on `start`; SETUP→SHIFT at the end of the half period; SHIFT→FINISH on the last rising edge of the frame; FINISH→QUIET always; QUIET→IDLE once the quiet count has run out.

Top module: `dual_adc_reader`

## Requirements
- R1: During and after reset, `cs_n`=1, `sclk`=1, `busy`=0, `done`=0, and both results are 0.
- R2: A `start` seen in IDLE pulls `cs_n` low in the following cycle. `sclk` is high at that moment and stays high for exactly DIV_HALF cycles before the first falling edge, so no clock edge coincides with the fall of the select. Whenever `cs_n` is high, `sclk` is high.
- R3: A frame has N serial clock periods (N falling and N rising edges). N is 14 for len16=0,dual=0; 16 for 1,0; 28 for 0,1; 32 for 1,1. `cs_n` stays low for 2·N·DIV_HALF cycles and rises after the Nth rising edge.
- R4: `sdata` is sampled on rising `sclk` edges. Let p be the position of a rising edge within its result segment, counting from 1. The edges with p = 2 to 13 supply result bits 11 down to 0. All other edges (leading and trailing zeros) are discarded.
- R5: With dual=1, the first segment fills `result_a` and the second segment (rising edges L+1 to 2L, where L is 14 or 16) fills `result_b`.
- R6: With dual=0, `result_b` keeps its previous value and only `result_a` is updated.
- R7: `done` is high for exactly one cycle: the first cycle in which `cs_n` is high again. Both results already hold the new frame's values in that cycle.
- R8: `busy` equals the inverse of `cs_n` in every cycle.
- R9: Between two frames, `cs_n` stays high for at least QUIET_CYC cycles. A `start` that arrives while a frame is in progress does not start another frame.
- R10: `len16` and `dual` are captured at `start`. Changing them during a frame has no effect on the edge count or on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one frame (taken in IDLE) |
| len16 | input | 1 | 1: 16 clocks per result, 0: 14 |
| dual | input | 1 | 1: read both channels in one frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | High while the select is low |
| done | output | 1 | One-cycle strobe when results are ready |
| result_a | output | 12 | First channel's word |
| result_b | output | 12 | Second channel's word |

## Verification
The assertions check on every cycle that the clock idles high whenever the select is high. They also check that the number of falling edges at each frame end matches the captured modes. Further per-cycle checks cover the single-cycle `done` strobe, the minimum high time of the select between frames, and the modes staying fixed during a frame. The bench's scenarios are needed to show what only a converter model can exercise. These are the bit alignment in every mode (leading and trailing zeros removed, MSB first), `result_b` holding its value after a single-channel frame, exact select-low durations, and a start pulse in mid-frame or a mode change in mid-frame leaving the frame unchanged.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_FINISH,
        ST_QUIET
    } rd_state_t;

    // number of framing zeros ahead of each result word
    localparam int LEAD_ZEROS = 2;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic shifting,
    output logic sclk,
    output logic setup_tick,
    output logic rise_tick
);
    localparam int DW = $clog2(DIV_HALF + 1);
    localparam logic [DW-1:0] HMAX = DW'(DIV_HALF - 1);

    logic [DW-1:0] hcnt;
    logic          sclk_q;
    logic          half_tick;

    assign half_tick = active && (hcnt == HMAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!active || half_tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
        end else if (!active) begin
            sclk_q <= 1'b1;
        end else if (half_tick) begin
            sclk_q <= ~sclk_q;
        end
    end

    assign sclk       = sclk_q;
    assign setup_tick = half_tick && !shifting;
    assign rise_tick  = half_tick && shifting && !sclk_q;

    // R2: the clock only moves while the link is active
    a_r2_sclk_still_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> $stable(sclk_q));

endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise_tick,
    input  logic             sdata,
    input  logic             len16,
    input  logic             dual,
    output logic             last_edge,
    output logic [RES_W-1:0] word_a,
    output logic [RES_W-1:0] word_b
);
    import adc_rd_pkg::*;

    localparam int SEG_S = RES_W + LEAD_ZEROS;
    localparam int SEG_L = RES_W + 2 * LEAD_ZEROS;
    localparam int CW    = $clog2(2 * SEG_L + 1);
    localparam logic [CW-1:0] FIRST_POS = CW'(LEAD_ZEROS);
    localparam logic [CW-1:0] LAST_POS  = CW'(RES_W + LEAD_ZEROS - 1);

    logic [CW-1:0]    rcnt;
    logic [CW-1:0]    rnext;
    logic [CW-1:0]    seg_len;
    logic [CW-1:0]    nclk;
    logic [CW-1:0]    pos;
    logic             in_b;
    logic             take;
    logic [RES_W-1:0] sh_a;
    logic [RES_W-1:0] sh_b;

    always_comb begin
        seg_len = len16 ? CW'(SEG_L) : CW'(SEG_S);
        nclk    = dual ? CW'(seg_len << 1) : seg_len;
        rnext   = rcnt + 1'b1;
        in_b    = rnext > seg_len;
        pos     = in_b ? (rnext - seg_len) : rnext;
        take    = (pos >= FIRST_POS) && (pos <= LAST_POS);
    end

    assign last_edge = rise_tick && (rnext == nclk);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt <= '0;
            sh_a <= '0;
            sh_b <= '0;
        end else if (clear) begin
            rcnt <= '0;
        end else if (rise_tick) begin
            rcnt <= rnext;
            if (take && !in_b) begin
                sh_a <= {sh_a[RES_W-2:0], sdata};
            end
            if (take && in_b) begin
                sh_b <= {sh_b[RES_W-2:0], sdata};
            end
        end
    end

    assign word_a = sh_a;
    assign word_b = sh_b;

    // R3: the edge counter never runs past the longest frame
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= CW'(2 * SEG_L));

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
    parameter int DIV_HALF  = 2,
    parameter int QUIET_CYC = 8,
    parameter int RES_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             len16,
    input  logic             dual,
    input  logic             sdata,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result_a,
    output logic [RES_W-1:0] result_b
);
    import adc_rd_pkg::*;

    localparam int QW = $clog2(QUIET_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(QUIET_CYC - 1);
    localparam int FW = $clog2(4 * (RES_W + 2 * LEAD_ZEROS) + 1);

    rd_state_t        state_q, state_d;
    logic [QW-1:0]    qcnt;
    logic             len16_q, dual_q;
    logic             setup_tick, rise_tick, last_edge;
    logic             link_on, shifting;
    logic [RES_W-1:0] word_a, word_b;

    assign link_on  = (state_q == ST_SETUP) || (state_q == ST_SHIFT);
    assign shifting = (state_q == ST_SHIFT);

    adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (link_on),
        .shifting   (shifting),
        .sclk       (sclk),
        .setup_tick (setup_tick),
        .rise_tick  (rise_tick)
    );

    adc_bit_capture #(.RES_W(RES_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .rise_tick (rise_tick),
        .sdata     (sdata),
        .len16     (len16_q),
        .dual      (dual_q),
        .last_edge (last_edge),
        .word_a    (word_a),
        .word_b    (word_b)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (setup_tick) state_d = ST_SHIFT;
            ST_SHIFT:  if (last_edge) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_QUIET;
            ST_QUIET:  if (qcnt == QMAX) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers: modes, quiet counter, results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len16_q  <= 1'b0;
            dual_q   <= 1'b0;
            qcnt     <= '0;
            result_a <= '0;
            result_b <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                len16_q <= len16;
                dual_q  <= dual;
            end
            if (state_q == ST_QUIET) begin
                qcnt <= qcnt + 1'b1;
            end else begin
                qcnt <= '0;
            end
            if (shifting && last_edge) begin
                result_a <= word_a;
                if (dual_q) begin
                    result_b <= word_b;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cs_n = !link_on;
        busy = link_on;
        done = (state_q == ST_FINISH);
    end

    // ---------------- checks ----------------
    logic          sclk_d;
    logic [FW-1:0] fall_cnt;
    logic [QW:0]   high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            fall_cnt <= '0;
            high_cnt <= (QW+1)'(QUIET_CYC);
        end else begin
            sclk_d <= sclk;
            if (cs_n) begin
                fall_cnt <= '0;
            end else if (sclk_d && !sclk) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
            if (!cs_n) begin
                high_cnt <= '0;
            end else if (high_cnt < (QW+1)'(QUIET_CYC)) begin
                high_cnt <= high_cnt + 1'b1;
            end
        end
    end

    a_r2_sclk_high_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    a_r2_no_edge_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (sclk && $past(sclk)));

    a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt == FW'((len16_q ? RES_W + 4 : RES_W + 2) * (dual_q ? 2 : 1))));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (high_cnt >= (QW+1)'(QUIET_CYC)));

    a_r10_modes_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len16_q) && $stable(dual_q)));

endmodule

// File: tb/dual_adc_reader_bench.sv
`timescale 1ns/1ps
module dual_adc_reader_bench;
    localparam int DIV_HALF  = 2;
    localparam int QUIET_CYC = 8;
    localparam int RES_W     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, len16 = 1'b0, dual = 1'b0, sdata = 1'b0;
    logic cs_n, sclk, busy, done;
    logic [RES_W-1:0] result_a, result_b;

    int n_checks = 0;
    int n_fail = 0;
    logic [0:63] fbits = '0;
    logic [RES_W-1:0] exp_b = '0;

    always #2 clk = ~clk;

    dual_adc_reader #(.DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC), .RES_W(RES_W)) u_dual_adc_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .len16(len16), .dual(dual),
        .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done),
        .result_a(result_a), .result_b(result_b)
    );

    // converter model: first zero present at select fall, next bit on each falling clock
    initial begin
        forever begin
            @(negedge cs_n);
            begin
                int idx;
                idx = 0;
                sdata = fbits[0];
                while (!cs_n) begin
                    @(negedge sclk or posedge cs_n);
                    if (!cs_n) begin
                        idx++;
                        #1 sdata = fbits[idx];
                    end
                end
                sdata = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    task automatic load_words(input bit l16, input bit du, input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
        int seg;
        seg = l16 ? RES_W + 4 : RES_W + 2;
        fbits = '0;
        for (int i = 0; i < RES_W; i++) begin
            fbits[2 + i] = a[RES_W-1-i];
            if (du) fbits[seg + 2 + i] = b[RES_W-1-i];
        end
        // trailing positions are filled with ones to prove they are dropped
        for (int i = RES_W + 2; i < seg; i++) fbits[i] = 1'b1;
    endtask

    // one frame, checked against R2, R3, R4, R5, R6, R7, R8, R10
    task automatic run_frame(input bit l16, input bit du, input logic [RES_W-1:0] a,
                             input logic [RES_W-1:0] b, input bit flip, input bit mid_start);
        int n, cslow, falls, setup, guard;
        bit prev_sclk, seen_fall, busy_bad;
        n = (l16 ? RES_W + 4 : RES_W + 2) * (du ? 2 : 1);
        load_words(l16, du, a, b);
        len16 = l16; dual = du; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cs_n == 1'b0 && sclk == 1'b1, "R2 select low with clock high", int'(cs_n), 0);
        cslow = 0; falls = 0; setup = 0; guard = 0;
        prev_sclk = 1'b1; seen_fall = 1'b0; busy_bad = 1'b0;
        while (cs_n == 1'b0 && guard < 2000) begin
            cslow++; guard++;
            if (busy != !cs_n) busy_bad = 1'b1;
            if (prev_sclk && !sclk) begin falls++; seen_fall = 1'b1; end
            if (!seen_fall && sclk) setup++;
            prev_sclk = sclk;
            if (flip && cslow == 3) begin len16 = ~l16; dual = ~du; end
            if (mid_start && cslow == 10) start = 1'b1;
            if (mid_start && cslow == 11) start = 1'b0;
            @(negedge clk);
        end
        check(setup == DIV_HALF, "R2 half period before first falling edge", setup, DIV_HALF);
        check(falls == n, "R3 falling edges per frame", falls, n);
        check(cslow == 2 * n * DIV_HALF, "R3 select low duration", cslow, 2 * n * DIV_HALF);
        check(!busy_bad && busy == 1'b0, "R8 busy follows select", int'(busy_bad), 0);
        check(done == 1'b1, "R7 done with select rising", int'(done), 1);
        check(result_a == a, "R4 result_a word", int'(result_a), int'(a));
        if (du) exp_b = b;
        check(result_b == exp_b, du ? "R5 result_b word" : "R6 result_b kept", int'(result_b), int'(exp_b));
        @(negedge clk);
        check(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
        len16 = 1'b0; dual = 1'b0;
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 select and clock idle high", int'({cs_n, sclk}), 3);
        check(busy == 1'b0 && done == 1'b0, "R1 busy and done low", int'({busy, done}), 0);
        check(result_a == '0 && result_b == '0, "R1 results cleared", int'(result_a), 0);
    endtask

    task automatic t_modes();
        run_frame(1'b0, 1'b0, 12'hA5C, 12'h000, 1'b0, 1'b0);   // 14 clocks, one channel
        repeat (QUIET_CYC + 3) @(negedge clk);
        run_frame(1'b1, 1'b0, 12'h3C1, 12'h000, 1'b0, 1'b0);   // 16 clocks, one channel
        repeat (QUIET_CYC + 3) @(negedge clk);
        run_frame(1'b0, 1'b1, 12'hFFF, 12'h801, 1'b0, 1'b0);   // 28 clocks, both
        repeat (QUIET_CYC + 3) @(negedge clk);
        run_frame(1'b1, 1'b1, 12'h001, 12'h7FE, 1'b0, 1'b0);   // 32 clocks, both
        repeat (QUIET_CYC + 3) @(negedge clk);
    endtask

    task automatic t_single_keeps_b();
        // R6: result_b must still show the previous dual frame's word
        run_frame(1'b0, 1'b0, 12'h555, 12'hBAD, 1'b0, 1'b0);
        repeat (QUIET_CYC + 3) @(negedge clk);
    endtask

    task automatic t_mode_flip();
        // R10: modes turned over mid-frame must not alter the frame
        run_frame(1'b0, 1'b1, 12'h9A3, 12'h16E, 1'b1, 1'b0);
        repeat (QUIET_CYC + 3) @(negedge clk);
    endtask

    task automatic t_start_while_busy();
        int extra;
        run_frame(1'b1, 1'b0, 12'hC3A, 12'h000, 1'b0, 1'b1);
        extra = 0;
        repeat (QUIET_CYC + 30) begin
            if (!cs_n) extra++;
            @(negedge clk);
        end
        check(extra == 0, "R9 start during frame ignored", extra, 0);
    endtask

    task automatic t_quiet();
        int gap, guard;
        load_words(1'b0, 1'b0, 12'h2D4, 12'h000);
        start = 1'b1;
        @(negedge clk);
        guard = 0;
        while (!cs_n && guard < 2000) begin guard++; @(negedge clk); end
        gap = 0;
        while (cs_n && guard < 4000) begin gap++; guard++; @(negedge clk); end
        check(gap >= QUIET_CYC, "R9 quiet gap between back-to-back frames", gap, QUIET_CYC);
        start = 1'b0;
        while (!cs_n && guard < 6000) begin guard++; @(negedge clk); end
        check(result_a == 12'h2D4, "R4 result_a after back-to-back frame", int'(result_a), 'h2D4);
        repeat (QUIET_CYC + 3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_modes();
        t_single_keeps_b();
        t_mode_flip();
        t_start_while_busy();
        t_quiet();
        finish_run();
    end

endmodule